// File: doc/BRIEF.md
# Manchester Line Receiver with Start-Synchronised Byte Queue

This block is the receive front end of a low-rate radio data link. An incoming serial line is oversampled with ticks from a programmable clock divider. Each half-bit of a Manchester (level) coded stream spans sixteen ticks. The block decodes the half-bit pairs into data bits, packs them into bytes and places the bytes in a four-entry queue. Software reads the queue through a small register port.

A message is framed by a deliberate coding violation: the line holds one level for three or more half-bits, then changes level. When start detection is enabled, this pattern synchronises the bit alignment, empties the queue and sets a start flag. Until the first such pattern after the receiver is enabled, nothing is decoded. An interrupt line follows one selectable condition, either the start flag or a full queue. A sticky flag records bytes lost because the queue was full.

Top module: `manrx_top`

## Requirements
- R1: The tick period is (F+1)·2^C clock cycles, where F is divider register bits [3:0] and C is bits [5:4]. One half-bit lasts 16 ticks. Reception is correct at settings 0x00 and 0x11.
- R2: A data bit 1 is sent as high then low, and a bit 0 as low then high. Bits arrive MSB first. Eight decoded bits form one byte.
- R3: The start pattern is three or more equal half-bit samples followed by one half-bit of the opposite level. The next half-bit opens the MSB of the first byte. The pattern sets the start flag, status bit 6.
- R4: While the receiver has not seen a start pattern since it was enabled, no byte enters the queue. The queue level (status bits [5:0]) stays 0.
- R5: The queue holds 4 bytes and returns them in arrival order. A read of address 3 returns the oldest byte and removes it. A read of address 3 on an empty queue returns 0.
- R6: A byte that completes while 4 bytes are held is dropped, and the overrun flag (status bit 7) is set. The stored bytes are kept.
- R7: Writing 1 to status bit 7 clears the overrun flag, and writing 1 to bit 6 clears the start flag. Clearing the receive enable (control bit 0) clears both flags.
- R8: A detected start pattern empties the queue, so only bytes of the new message remain.
- R9: With start detection off (control bit 1 = 0), a start pattern neither empties the queue nor sets the start flag.
- R10: The interrupt select is control bits [4:2]. With code 001 the interrupt is high while the start flag is set. With code 100 it is high while the queue is full. Any other code, or a cleared receive enable, holds it low.
- R11: After reset, the control, divider and status registers read 0 and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | Manchester coded serial line (asynchronous) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops the queue at address 3 |
| reg_addr | input | 2 | Register select: 0 control, 1 divider, 2 status, 3 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt, level high |

## Verification
The bench builds the block with its default parameters: a queue depth of 4, a 4-bit fine divide field and a 2-bit coarse field. A depth of 4 means a five-byte message reaches overrun, and two back-to-back messages reach the flush. The bench runs the divider at one and at four clock cycles per tick. This covers both the single-cycle tick case and resynchronisation of the phase counter on edges that fall between ticks.

// File: rtl/manrx_pkg.sv
// Shared definitions for the Manchester line receiver.
// Assumes an 8-bit register port; the control layout is fixed by the struct order.
package manrx_pkg;

    localparam int          REG_W        = 8;
    localparam int          SEL_W        = 3;
    localparam logic [2:0]  IRQ_ON_START = 3'b001;
    localparam logic [2:0]  IRQ_ON_FULL  = 3'b100;

    localparam logic [1:0]  ADR_CTRL = 2'd0;
    localparam logic [1:0]  ADR_DIV  = 2'd1;
    localparam logic [1:0]  ADR_STAT = 2'd2;
    localparam logic [1:0]  ADR_DATA = 2'd3;

    // control register: bits [4:2] irq select, bit 1 start detect, bit 0 enable
    typedef struct packed {
        logic [SEL_W-1:0] irq_sel;
        logic             start_en;
        logic             rx_en;
    } ctrl_t;

endpackage

// File: rtl/manrx_baud.sv
// Oversampling tick generator.
// Emits a one-cycle tick every (fine+1) * 2^coarse clocks while enabled.
// Assumes the count limit fits in CNT_W bits (derived from the field widths).
module manrx_baud #(
    parameter int FINE_W   = 4,
    parameter int COARSE_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [FINE_W-1:0]   fine,
    input  logic [COARSE_W-1:0] coarse,
    output logic                tick
);
    localparam int MAX_PROD = (1 << FINE_W) * (1 << ((1 << COARSE_W) - 1));
    localparam int CNT_W    = $clog2(MAX_PROD);

    logic [CNT_W:0]   prod;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt;

    // Divide product minus one gives the terminal count.
    always_comb begin
        prod  = ((CNT_W+1)'(fine) + (CNT_W+1)'(1)) << coarse;
        limit = CNT_W'(prod - (CNT_W+1)'(1));
    end

    // Prescaler counter and registered tick pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= limit) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + CNT_W'(1);
            tick <= 1'b0;
        end
    end

    // R1
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && limit != '0) |=> (!tick || limit != $past(limit)));

endmodule

// File: rtl/manrx_dec.sv
// Manchester half-bit sampler, start-violation detector and byte packer.
// Samples each half-bit OVS/2 ticks after the last line edge, re-aligning on
// every edge. A run of three equal halves broken by the opposite level is a
// start pattern. Assumes OVS and DATA_W are powers of two.
module manrx_dec #(
    parameter int OVS    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              start_en,
    input  logic              tick,
    input  logic              line_in,
    output logic              start_pulse,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_data
);
    localparam int             PH_W     = $clog2(OVS);
    localparam int             BC_W     = $clog2(DATA_W);
    localparam logic [PH_W-1:0] MID     = PH_W'(OVS/2 - 1);
    localparam logic [BC_W-1:0] LAST    = BC_W'(DATA_W - 1);
    localparam logic [1:0]     RUN_MAX  = 2'd3;

    logic            line_m, line_s, last_lvl;
    logic [PH_W-1:0] phase;
    logic            prev_half, synced, second, first;
    logic [1:0]      run;
    logic [BC_W-1:0] bitcnt;
    logic            samp, brk;

    // Two-flop synchroniser for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_m <= 1'b0;
            line_s <= 1'b0;
        end else begin
            line_m <= line_in;
            line_s <= line_m;
        end
    end

    // Sample strobe at mid half-bit; break of a long run of equal halves.
    always_comb begin
        samp = tick && (line_s == last_lvl) && (phase == MID);
        brk  = (line_s != prev_half) && (run == RUN_MAX);
    end

    // Phase tracking, run counting, alignment and bit packing.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            last_lvl    <= 1'b0;
            phase       <= '0;
            prev_half   <= 1'b0;
            run         <= 2'd0;
            synced      <= 1'b0;
            second      <= 1'b0;
            first       <= 1'b0;
            bitcnt      <= '0;
            byte_data   <= '0;
            start_pulse <= 1'b0;
            byte_valid  <= 1'b0;
        end else begin
            start_pulse <= 1'b0;
            byte_valid  <= 1'b0;
            if (tick) begin
                last_lvl <= line_s;
                phase    <= (line_s != last_lvl) ? '0 : phase + PH_W'(1);
            end
            if (samp) begin
                prev_half <= line_s;
                if (line_s != prev_half)  run <= 2'd1;
                else if (run != RUN_MAX)  run <= run + 2'd1;
                if (start_en && brk) begin
                    start_pulse <= 1'b1;
                    synced      <= 1'b1;
                    second      <= 1'b0;
                    bitcnt      <= '0;
                end else if (synced) begin
                    if (!second) begin
                        first  <= line_s;
                        second <= 1'b1;
                    end else begin
                        second <= 1'b0;
                        if (first != line_s) begin
                            byte_data <= {byte_data[DATA_W-2:0], first};
                            bitcnt    <= bitcnt + BC_W'(1);
                            if (bitcnt == LAST) byte_valid <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    // R9
    start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> $past(start_en));

    // R3
    start_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !byte_valid);

endmodule

// File: rtl/manrx_fifo.sv
// Small byte queue with synchronous flush. Pushes while full are refused;
// pops while empty are ignored. Head reads as zero when empty.
module manrx_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Accepted operations and flags.
    always_comb begin
        full    = (level == LVL_W'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && (level != '0);
        dout    = (level != '0) ? mem[rd_ptr] : '0;
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= din;
    end

    // Pointer and level bookkeeping, cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   level <= level + LVL_W'(1);
                2'b01:   level <= level - LVL_W'(1);
                default: level <= level;
            endcase
        end
    end

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    // R6
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> full);

endmodule

// File: rtl/manrx_top.sv
// Manchester receiver top: register port, flags, interrupt, and the
// divider / decoder / queue instances. Assumes an 8-bit register port.
module manrx_top #(
    parameter int DEPTH    = 4,
    parameter int FINE_W   = 4,
    parameter int COARSE_W = 2,
    parameter int DATA_W   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_in,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq
);
    import manrx_pkg::*;

    localparam int LVL_W = $clog2(DEPTH + 1);

    ctrl_t               ctrl;
    logic [FINE_W-1:0]   fine;
    logic [COARSE_W-1:0] coarse;
    logic                ovr, start_flag;
    logic                tick, start_pulse, byte_valid;
    logic [DATA_W-1:0]   byte_data, head;
    logic [LVL_W-1:0]    level;
    logic                full, pop, stat_wr;

    // Control and divider register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl   <= '0;
            fine   <= '0;
            coarse <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADR_CTRL) ctrl <= ctrl_t'(reg_wdata[$bits(ctrl_t)-1:0]);
            if (reg_addr == ADR_DIV) begin
                fine   <= reg_wdata[FINE_W-1:0];
                coarse <= reg_wdata[FINE_W +: COARSE_W];
            end
        end
    end

    // Queue pop and status write-one-to-clear strobe.
    always_comb begin
        pop     = reg_rd && (reg_addr == ADR_DATA);
        stat_wr = reg_wr && (reg_addr == ADR_STAT);
    end

    // Sticky overrun and start flags.
    always_ff @(posedge clk) begin
        if (!rst_n || !ctrl.rx_en) begin
            ovr        <= 1'b0;
            start_flag <= 1'b0;
        end else begin
            if (byte_valid && full)         ovr <= 1'b1;
            else if (stat_wr && reg_wdata[7]) ovr <= 1'b0;
            if (start_pulse)                start_flag <= 1'b1;
            else if (stat_wr && reg_wdata[6]) start_flag <= 1'b0;
        end
    end

    // Interrupt follows the selected condition.
    always_comb begin
        irq = 1'b0;
        if (ctrl.rx_en) begin
            if (ctrl.irq_sel == IRQ_ON_START) irq = start_flag;
            else if (ctrl.irq_sel == IRQ_ON_FULL) irq = full;
        end
    end

    // Read data multiplexer.
    always_comb begin
        case (reg_addr)
            ADR_CTRL: reg_rdata = REG_W'(ctrl);
            ADR_DIV:  reg_rdata = REG_W'({coarse, fine});
            ADR_STAT: reg_rdata = {ovr, start_flag, (REG_W-2)'(level)};
            default:  reg_rdata = REG_W'(head);
        endcase
    end

    manrx_baud #(.FINE_W(FINE_W), .COARSE_W(COARSE_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .en(ctrl.rx_en),
        .fine(fine), .coarse(coarse), .tick(tick)
    );

    manrx_dec #(.OVS(16), .DATA_W(DATA_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .en(ctrl.rx_en), .start_en(ctrl.start_en),
        .tick(tick), .line_in(line_in), .start_pulse(start_pulse),
        .byte_valid(byte_valid), .byte_data(byte_data)
    );

    manrx_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(start_pulse),
        .push(byte_valid), .din(byte_data), .pop(pop),
        .dout(head), .level(level), .full(full)
    );

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> (level == '0));

    // R6
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && full && ctrl.rx_en) |=> ovr);

    // R7
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && ctrl.rx_en && !(stat_wr && reg_wdata[7])) |=> ovr);

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctrl.rx_en);

endmodule

// File: tb/manrx_top_test.sv
// Scoreboard bench: the driver queues expected bytes, the reader pops and compares.
module manrx_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_in = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq;

    int total = 0;
    int bad = 0;
    int half_clks = 16;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    manrx_top uut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic send_half(input logic b);
        line_in = b;
        repeat (half_clks) @(negedge clk);
    endtask

    // Driver: start pattern, n bytes MSB first, trailing idle; queues the first nkeep.
    task automatic send_msg(input int n, input int nkeep, input logic [7:0] b0, b1, b2, b3, b4);
        logic [7:0] m [5];
        m[0] = b0; m[1] = b1; m[2] = b2; m[3] = b3; m[4] = b4;
        for (int i = 0; i < 6; i++) send_half(1'b0);
        send_half(1'b1);
        for (int k = 0; k < n; k++) begin
            for (int j = 7; j >= 0; j--) begin
                send_half(m[k][j]);
                send_half(!m[k][j]);
            end
            if (k < nkeep) exp_q.push_back(m[k]);
        end
        for (int i = 0; i < 3; i++) send_half(1'b0);
    endtask

    // Reader side of the scoreboard.
    task automatic drain(input int n, input string req);
        logic [7:0] d, e;
        for (int i = 0; i < n; i++) begin
            reg_read(2'd3, d);
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
            check(d === e, req, 32'(d), 32'(e));
        end
    endtask

    task automatic expect_reg(input logic [1:0] a, input logic [7:0] e, input string req);
        logic [7:0] d;
        reg_read(a, d);
        check(d === e, req, 32'(d), 32'(e));
    endtask

    task automatic expect_irq(input logic e, input string req);
        @(negedge clk);
        check(irq === e, req, 32'(irq), 32'(e));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        expect_reg(2'd0, 8'h00, "R11 ctrl");
        expect_reg(2'd1, 8'h00, "R11 div");
        expect_reg(2'd2, 8'h00, "R11 status");
        expect_irq(1'b0, "R11 irq");

        // R4: enabled without start detection, never synchronised
        reg_write(2'd0, 8'h01);
        send_msg(2, 0, 8'h5A, 8'hC3, 8'h00, 8'h00, 8'h00);
        expect_reg(2'd2, 8'h00, "R4 level");

        // R2 R3 R5 R10: start-flag interrupt, two bytes
        reg_write(2'd0, 8'h07);
        send_msg(2, 2, 8'hA5, 8'h3C, 8'h00, 8'h00, 8'h00);
        expect_reg(2'd2, 8'h42, "R3 flag and level");
        expect_irq(1'b1, "R10 start irq");
        drain(2, "R2 R5 order");
        expect_reg(2'd3, 8'h00, "R5 empty read");
        reg_write(2'd2, 8'h40);
        expect_reg(2'd2, 8'h00, "R7 start flag clear");
        expect_irq(1'b0, "R10 start irq low");

        // R10 full interrupt
        reg_write(2'd0, 8'h13);
        send_msg(4, 4, 8'h01, 8'h80, 8'hFF, 8'h00, 8'h00);
        expect_reg(2'd2, 8'h44, "R5 four held");
        expect_irq(1'b1, "R10 full irq");
        drain(4, "R5 full drain");
        expect_irq(1'b0, "R10 full irq low");
        reg_write(2'd2, 8'h40);

        // R6 overrun, R7 clear by write
        send_msg(5, 4, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
        expect_reg(2'd2, 8'hC4, "R6 overrun");
        drain(4, "R6 kept bytes");
        reg_write(2'd2, 8'hC0);
        expect_reg(2'd2, 8'h00, "R7 write clear");

        // R7 clear by disable
        send_msg(5, 4, 8'h66, 8'h77, 8'h88, 8'h99, 8'hAA);
        drain(4, "R6 second run");
        reg_write(2'd0, 8'h00);
        expect_reg(2'd2, 8'h00, "R7 disable clear");
        expect_irq(1'b0, "R10 disabled");
        reg_write(2'd0, 8'h13);

        // R8 flush on new start
        send_msg(3, 0, 8'h12, 8'h34, 8'h56, 8'h00, 8'h00);
        expect_reg(2'd2, 8'h43, "R8 pre-flush level");
        send_msg(1, 1, 8'h9E, 8'h00, 8'h00, 8'h00, 8'h00);
        expect_reg(2'd2, 8'h41, "R8 after flush");
        drain(1, "R8 new byte");

        // R9 start detection disabled
        send_msg(2, 2, 8'hC3, 8'h5A, 8'h00, 8'h00, 8'h00);
        reg_write(2'd2, 8'h40);
        reg_write(2'd0, 8'h11);
        send_msg(0, 0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        expect_reg(2'd2, 8'h02, "R9 no flush");
        drain(2, "R9 bytes intact");

        // R10 unused select code
        reg_write(2'd0, 8'h0B);
        send_msg(1, 1, 8'h77, 8'h00, 8'h00, 8'h00, 8'h00);
        expect_irq(1'b0, "R10 other code");
        drain(1, "R10 byte");

        // R1 slower divider: 4 clocks per tick
        reg_write(2'd0, 8'h00);
        reg_write(2'd1, 8'h11);
        expect_reg(2'd1, 8'h11, "R1 div readback");
        half_clks = 64;
        reg_write(2'd0, 8'h07);
        send_msg(2, 2, 8'hE1, 8'h4B, 8'h00, 8'h00, 8'h00);
        expect_reg(2'd2, 8'h42, "R1 level");
        drain(2, "R1 bytes");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule